// File: doc/BRIEF.md
# Digital PWM-Bias Segment LCD Driver

This block drives a multiplexed segment LCD straight from digital output pins. It needs no charge pump and no resistor ladder. The intermediate voltages a multiplexed panel needs are made by density modulation: each pin toggles between the rails with a duty cycle equal to the wanted fraction of the supply. The low-pass response of the glass averages that stream down to the intermediate level. Every pin is configured at run time as either a common or a segment. The same per-pin decode serves both roles.

A free-running sequencer gives one sub-frame to each common and wraps once all commons have been served. At every wrap it flips a polarity flag, so the glass sees no net DC over two frames. Two streams come from a shared step counter: a low-bias stream and a high-bias stream. Their duty cycles set the bias ratio, which may be one half, one third or one quarter. A programmable dead window at the end of each modulation period pulls every pin low, which lowers the RMS drive and so the contrast. Two drive schemes can be chosen while running: the density-modulated one described above, and a digital-correlation scheme built from two uncorrelated square waves.

Pixel data is written into a pending bank, one row per pin. The pending bank is copied to the bank that is displayed only when a frame wraps, so the panel never shows a half-written image.

Top module: `lcd_pwm_drive`

## Requirements
- R1: While `rst` is high at a clock edge, the sequencer returns to step 0, modulation period 0, sub-frame 0 and polarity 0, and both pixel banks are cleared to all-off.
- R2: One modulation period is STEPS clocks, indexed by step s = 0..STEPS-1. One sub-frame is PER_SF periods. `sub_frame` counts 0..2^COM_W-1 and then wraps to 0.
- R3: `inv_flag` toggles on the clock edge where `sub_frame` wraps from its last value to 0, and at no other edge.
- R4: `bias_sel` 0, 1, 2 and 3 select divisors d = 2, 3, 4 and 4. The low stream is 1 when s < STEPS/d. The high stream is 1 when s < STEPS - STEPS/d.
- R5: When s + `dead_len` >= STEPS, every `lcd_pin` bit is 0 in both drive schemes. `dead_len` = 0 never blanks, and `dead_len` = STEPS always blanks.
- R6: In density mode (`method` = 1), a common pin whose assigned common equals `sub_frame` outputs NOT `inv_flag`. An unassigned common pin outputs the low stream when `inv_flag` = 0 and the high stream when `inv_flag` = 1.
- R7: In density mode, a segment pin whose displayed pixel bit for the current sub-frame is 1 outputs `inv_flag`. If that bit is 0, the pin outputs the high stream when `inv_flag` = 0 and the low stream when `inv_flag` = 1.
- R8: In correlation mode (`method` = 0), let F = (s < STEPS/2) XOR `inv_flag`. A selected common outputs F. An unselected common outputs (period index bit 0) XOR `inv_flag`. A segment with its pixel on outputs NOT F, and with its pixel off outputs F.
- R9: `pin_mode[i]` = 0 makes pin i a common, and `pin_mode[i]` = 1 makes it a segment. Common pin i is assigned common number i mod 2^COM_W.
- R10: A write with `wr_en` = 1 stores `wr_data` as the row of pin `wr_addr`. Bit c of the row is the pixel shown during sub-frame c. The row becomes visible only after the next frame wrap (the edge where `sub_frame` goes from its last value to 0).
- R11: A write whose `wr_addr` is NUM_PINS or higher changes no pixel row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| method | input | 1 | 1 = density modulation, 0 = digital correlation |
| bias_sel | input | 2 | Bias ratio code (0: 1/2, 1: 1/3, 2 and 3: 1/4) |
| dead_len | input | $clog2(STEPS+1) | Dead-window length in steps at the end of each period |
| pin_mode | input | NUM_PINS | Per-pin role, 0 = common, 1 = segment |
| wr_en | input | 1 | Pixel row write strobe |
| wr_addr | input | $clog2(NUM_PINS)+1 | Pin index of the row written |
| wr_data | input | 2^COM_W | Pixel row, bit c shown during sub-frame c |
| lcd_pin | output | NUM_PINS | Drive level for each panel pin |
| sub_frame | output | COM_W | Current sub-frame index |
| inv_flag | output | 1 | Current polarity phase |

## Verification
The bench writes pixel rows part way through a frame. A design that loads them at once shows a torn image, and the segment levels then disagree with the model until the next wrap. It also writes to addresses past the last pin, which a design that drops the range check folds onto a real row. The bench sweeps every bias code, including the spare code 3, and both drive schemes. It uses dead windows of zero, mid-range and full length. An off-by-one in a duty threshold or in the dead-window compare shifts one edge of a stream by one step, and that shows at the boundary step. A swapped high/low stream choice for one polarity shows only in alternate frames. Pin roles are changed part way through the run, so a wrong common-number mapping or a role decode that is stuck on one type is exposed.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

    typedef enum logic [1:0] {
        BIAS_HALF    = 2'd0,
        BIAS_THIRD   = 2'd1,
        BIAS_QUARTER = 2'd2,
        BIAS_SPARE   = 2'd3
    } bias_sel_e;

    typedef enum logic {
        DRV_CORR    = 1'b0,
        DRV_DENSITY = 1'b1
    } drive_mode_e;

    typedef enum logic {
        PIN_COMMON  = 1'b0,
        PIN_SEGMENT = 1'b1
    } pin_role_e;

    // Waveform primitives shared by every pin cell
    typedef struct packed {
        logic bias_hi;
        logic bias_lo;
        logic dead;
        logic corr_fast;
        logic corr_slow;
    } wave_t;

    function automatic int bias_divisor(bias_sel_e sel);
        case (sel)
            BIAS_HALF:  return 2;
            BIAS_THIRD: return 3;
            default:    return 4;
        endcase
    endfunction

endpackage

// File: rtl/lcd_seq.sv
module lcd_seq #(
    parameter int COM_W  = 2,
    parameter int STEPS  = 12,
    parameter int PER_SF = 16,
    localparam int SW    = $clog2(STEPS),
    localparam int PW    = $clog2(PER_SF)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [SW-1:0]    step_o,
    output logic             per_lsb_o,
    output logic [COM_W-1:0] sf_o,
    output logic             inv_o,
    output logic             frame_end_o
);
    logic [SW-1:0]    step_q;
    logic [PW-1:0]    per_q;
    logic [COM_W-1:0] sf_q;
    logic             inv_q;
    logic             step_last, per_last, sf_adv;

    assign step_last   = (step_q == SW'(STEPS - 1));
    assign per_last    = (per_q == PW'(PER_SF - 1));
    assign sf_adv      = step_last && per_last;
    assign frame_end_o = sf_adv && (sf_q == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
            per_q  <= '0;
            sf_q   <= '0;
            inv_q  <= 1'b0;
        end else begin
            step_q <= step_last ? '0 : step_q + 1'b1;
            if (step_last)
                per_q <= per_last ? '0 : per_q + 1'b1;
            if (sf_adv)
                sf_q <= sf_q + 1'b1;
            if (frame_end_o)
                inv_q <= ~inv_q;
        end
    end

    assign step_o    = step_q;
    assign per_lsb_o = per_q[0];
    assign sf_o      = sf_q;
    assign inv_o     = inv_q;

    // R2
    sf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sf_adv |=> $stable(sf_q));
    // R2
    sf_step_chk: assert property (@(posedge clk) disable iff (rst)
        sf_adv |=> (sf_q - $past(sf_q)) == COM_W'(1));
    // R3
    inv_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end_o |=> inv_q != $past(inv_q));
    // R3
    inv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_end_o |=> $stable(inv_q));

endmodule

// File: rtl/lcd_wavegen.sv
module lcd_wavegen
    import lcd_drv_pkg::*;
#(
    parameter int STEPS = 12,
    localparam int SW   = $clog2(STEPS),
    localparam int DW   = $clog2(STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] step_i,
    input  logic          per_lsb_i,
    input  bias_sel_e     bias_sel_i,
    input  logic [DW-1:0] dead_len_i,
    output wave_t         wave_o
);
    int lo_n;

    always_comb begin
        lo_n = STEPS / bias_divisor(bias_sel_i);
        wave_o.bias_lo   = int'(step_i) < lo_n;
        wave_o.bias_hi   = int'(step_i) < (STEPS - lo_n);
        wave_o.dead      = (int'(step_i) + int'(dead_len_i)) >= STEPS;
        wave_o.corr_fast = int'(step_i) < (STEPS / 2);
        wave_o.corr_slow = per_lsb_i;
    end

    // R4
    bias_order_chk: assert property (@(posedge clk) disable iff (rst)
        wave_o.bias_lo |-> wave_o.bias_hi);

endmodule

// File: rtl/lcd_pixel_bank.sv
module lcd_pixel_bank #(
    parameter int NUM_PINS = 8,
    parameter int NCOM     = 4,
    localparam int IW      = $clog2(NUM_PINS),
    localparam int AW      = IW + 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [AW-1:0]                      wr_addr,
    input  logic [NCOM-1:0]                    wr_data,
    input  logic                               frame_end,
    output logic [NUM_PINS-1:0][NCOM-1:0]      rows_o
);
    logic [NUM_PINS-1:0][NCOM-1:0] pend_q, show_q;
    logic                          wr_ok;

    assign wr_ok = wr_en && (int'(wr_addr) < NUM_PINS);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            show_q <= '0;
        end else begin
            if (wr_ok)
                pend_q[wr_addr[IW-1:0]] <= wr_data;
            if (frame_end)
                show_q <= pend_q;
        end
    end

    assign rows_o = show_q;

    // R10
    show_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(show_q));
    // R11
    bad_addr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_ok) |=> $stable(pend_q));

endmodule

// File: rtl/lcd_pin_cell.sv
module lcd_pin_cell
    import lcd_drv_pkg::*;
#(
    parameter int COM_W   = 2,
    parameter int PIN_IDX = 0,
    localparam int NCOM   = 1 << COM_W,
    localparam int OWN    = PIN_IDX % NCOM
) (
    input  pin_role_e        role_i,
    input  drive_mode_e      method_i,
    input  wave_t            wave_i,
    input  logic [COM_W-1:0] sf_i,
    input  logic             inv_i,
    input  logic [NCOM-1:0]  row_i,
    output logic             pin_o
);
    logic selected, pix_on, fast;

    always_comb begin
        selected = (sf_i == COM_W'(OWN));
        pix_on   = row_i[sf_i];
        fast     = wave_i.corr_fast ^ inv_i;
        pin_o    = 1'b0;
        if (wave_i.dead) begin
            pin_o = 1'b0;
        end else if (method_i == DRV_DENSITY) begin
            if (role_i == PIN_COMMON)
                pin_o = selected ? ~inv_i : (inv_i ? wave_i.bias_hi : wave_i.bias_lo);
            else
                pin_o = pix_on ? inv_i : (inv_i ? wave_i.bias_lo : wave_i.bias_hi);
        end else begin
            if (role_i == PIN_COMMON)
                pin_o = selected ? fast : (wave_i.corr_slow ^ inv_i);
            else
                pin_o = pix_on ? ~fast : fast;
        end
    end

endmodule

// File: rtl/lcd_pwm_drive.sv
module lcd_pwm_drive
    import lcd_drv_pkg::*;
#(
    parameter int COM_W    = 2,
    parameter int NUM_PINS = 8,
    parameter int STEPS    = 12,
    parameter int PER_SF   = 16,
    localparam int NCOM    = 1 << COM_W,
    localparam int SW      = $clog2(STEPS),
    localparam int DW      = $clog2(STEPS + 1),
    localparam int AW      = $clog2(NUM_PINS) + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                method,
    input  logic [1:0]          bias_sel,
    input  logic [DW-1:0]       dead_len,
    input  logic [NUM_PINS-1:0] pin_mode,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [NCOM-1:0]     wr_data,
    output logic [NUM_PINS-1:0] lcd_pin,
    output logic [COM_W-1:0]    sub_frame,
    output logic                inv_flag
);
    logic [SW-1:0]                 step;
    logic                          per_lsb, frame_end, inv;
    logic [COM_W-1:0]              sf;
    wave_t                         wave;
    logic [NUM_PINS-1:0][NCOM-1:0] rows;

    lcd_seq #(.COM_W(COM_W), .STEPS(STEPS), .PER_SF(PER_SF)) u_seq (
        .clk(clk), .rst(rst), .step_o(step), .per_lsb_o(per_lsb),
        .sf_o(sf), .inv_o(inv), .frame_end_o(frame_end)
    );

    lcd_wavegen #(.STEPS(STEPS)) u_wave (
        .clk(clk), .rst(rst), .step_i(step), .per_lsb_i(per_lsb),
        .bias_sel_i(bias_sel_e'(bias_sel)), .dead_len_i(dead_len), .wave_o(wave)
    );

    lcd_pixel_bank #(.NUM_PINS(NUM_PINS), .NCOM(NCOM)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_end(frame_end), .rows_o(rows)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        lcd_pin_cell #(.COM_W(COM_W), .PIN_IDX(i)) u_cell (
            .role_i(pin_role_e'(pin_mode[i])),
            .method_i(drive_mode_e'(method)),
            .wave_i(wave), .sf_i(sf), .inv_i(inv),
            .row_i(rows[i]), .pin_o(lcd_pin[i])
        );
    end

    assign sub_frame = sf;
    assign inv_flag  = inv;

    // R5
    dead_low_chk: assert property (@(posedge clk) disable iff (rst)
        wave.dead |-> (lcd_pin == '0));

endmodule

// File: tb/lcd_pwm_drive_test.sv
module lcd_pwm_drive_test;
    localparam int CLK_PERIOD = 10;
    localparam int COM_W    = 2;
    localparam int NUM_PINS = 8;
    localparam int STEPS    = 12;
    localparam int PER_SF   = 16;
    localparam int NCOM     = 1 << COM_W;
    localparam int DW       = $clog2(STEPS + 1);
    localparam int AW       = $clog2(NUM_PINS) + 1;
    localparam int FRAME    = STEPS * PER_SF * NCOM;

    // {pin_mode[7:0], method, bias_sel[1:0], dead_len[3:0]}
    localparam logic [14:0] VEC [8] = '{
        {8'b1111_0000, 1'b1, 2'd0, 4'd0},
        {8'b1111_0000, 1'b1, 2'd1, 4'd0},
        {8'b1111_0000, 1'b1, 2'd2, 4'd0},
        {8'b1111_0000, 1'b1, 2'd1, 4'd3},
        {8'b1111_0000, 1'b0, 2'd0, 4'd0},
        {8'b0101_1010, 1'b0, 2'd2, 4'd5},
        {8'b0101_1010, 1'b1, 2'd2, 4'd12},
        {8'b0101_1010, 1'b1, 2'd3, 4'd1}
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                method = 1'b1;
    logic [1:0]          bias_sel = '0;
    logic [DW-1:0]       dead_len = '0;
    logic [NUM_PINS-1:0] pin_mode = 8'b1111_0000;
    logic                wr_en = 1'b0;
    logic [AW-1:0]       wr_addr = '0;
    logic [NCOM-1:0]     wr_data = '0;
    logic [NUM_PINS-1:0] lcd_pin;
    logic [COM_W-1:0]    sub_frame;
    logic                inv_flag;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_pwm_drive uut (
        .clk(clk), .rst(rst), .method(method), .bias_sel(bias_sel),
        .dead_len(dead_len), .pin_mode(pin_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .lcd_pin(lcd_pin),
        .sub_frame(sub_frame), .inv_flag(inv_flag)
    );

    // Reference time base and pixel banks
    int              t;
    bit [NCOM-1:0]   pend_m [NUM_PINS];
    bit [NCOM-1:0]   show_m [NUM_PINS];

    always @(posedge clk) begin
        if (rst) begin
            t <= 0;
            foreach (pend_m[i]) begin
                pend_m[i] <= '0;
                show_m[i] <= '0;
            end
        end else begin
            t <= t + 1;
            if (t % FRAME == FRAME - 1)
                show_m <= pend_m;
            if (wr_en && int'(wr_addr) < NUM_PINS)  // R11: out of range ignored
                pend_m[int'(wr_addr)] <= wr_data;
        end
    end

    function automatic logic [NUM_PINS-1:0] exp_pins();
        logic [NUM_PINS-1:0] r;
        int s, per, sf, d, lo_n;
        bit inv, lo, hi, f, on;
        s    = t % STEPS;
        per  = (t / STEPS) % PER_SF;
        sf   = (t / (STEPS * PER_SF)) % NCOM;
        inv  = ((t / FRAME) % 2) == 1;
        d    = (bias_sel == 2'd0) ? 2 : (bias_sel == 2'd1) ? 3 : 4;
        lo_n = STEPS / d;
        lo   = s < lo_n;
        hi   = s < STEPS - lo_n;
        f    = (s < STEPS / 2) ^ inv;
        for (int i = 0; i < NUM_PINS; i++) begin
            on = show_m[i][sf];
            if (s + int'(dead_len) >= STEPS) r[i] = 1'b0;        // R5
            else if (method) begin
                if (!pin_mode[i])                                  // R6, R9
                    r[i] = (i % NCOM == sf) ? !inv : (inv ? hi : lo);
                else                                               // R7
                    r[i] = on ? inv : (inv ? lo : hi);
            end else begin                                         // R8
                if (!pin_mode[i])
                    r[i] = (i % NCOM == sf) ? f : ((per % 2 == 1) ^ inv);
                else
                    r[i] = on ? !f : f;
            end
        end
        return r;
    endfunction

    task automatic check_now(input string tag);
        logic [NUM_PINS-1:0] e;
        int esf;
        bit einv;
        e    = exp_pins();
        esf  = (t / (STEPS * PER_SF)) % NCOM;
        einv = ((t / FRAME) % 2) == 1;
        total++;
        if (lcd_pin !== e) begin
            fails++;
            $display("FAIL %s lcd_pin actual %b expected %b (t=%0d)", tag, lcd_pin, e, t);
        end
        total++;
        if (int'(sub_frame) != esf || inv_flag !== einv) begin
            fails++;
            $display("FAIL R2 R3 sub_frame/inv actual %0d/%b expected %0d/%b", sub_frame, inv_flag, esf, einv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        fails++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        total++;
        if (sub_frame !== '0 || inv_flag !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset actual sf=%0d inv=%b expected 0/0", sub_frame, inv_flag);
        end
        check_now("R1");
        @(negedge clk);
        rst = 1'b0;
        // initial pixel image, written mid-frame (R10)
        for (int p = 0; p < NUM_PINS; p++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = AW'(p); wr_data = NCOM'(p * 5 + 3);
            #1; check_now("R10");
        end
        @(negedge clk); wr_en = 1'b0;

        foreach (VEC[v]) begin
            @(negedge clk);
            pin_mode = VEC[v][14:7];
            method   = VEC[v][6];
            bias_sel = VEC[v][5:4];
            dead_len = VEC[v][3:0];
            wr_en = 1'b1; wr_addr = AW'(4 + v % 4); wr_data = NCOM'(v * 7 + 1);
            #1; check_now(method ? "R4 R6 R7 R9 R10" : "R8 R9 R10");
            @(negedge clk);
            wr_addr = AW'(NUM_PINS + v % 8); wr_data = '1;
            #1; check_now("R11");
            @(negedge clk); wr_en = 1'b0;
            for (int c = 0; c < 2 * FRAME + 20; c++) begin
                @(negedge clk); #1;
                check_now(dead_len != 0 ? "R5" : (method ? "R4 R6 R7" : "R8"));
            end
        end

        // R1: reset in the middle of a run clears the display
        @(negedge clk); rst = 1'b1;
        @(negedge clk); #1; check_now("R1");
        @(negedge clk); rst = 1'b0;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk); #1; check_now("R1");
        end
        finish_run();
    end
endmodule